// File: doc/BRIEF.md
# Channel-Prioritized Interrupt Controller

This block takes a parameterized set of system interrupt lines (64 by default) and conditions each line according to its own polarity bit and its own level/edge type bit. A per-line status bit records what is pending. Each line that is both pending and enabled is steered to one of 32 numbered priority channels by an 8-bit channel number held in a packed map. The lowest-numbered live channel wins. Channels 0 and 1 raise the fast request `fiq_o`. Channels 2 to 31 raise the normal request `irq_o`.

Software reaches the block over a simple word-addressed register port. The write side has one strobe and completes in a single cycle with no back-pressure: every write is accepted on the clock edge where `wr_en_i` is high. The read side is combinational from `rd_addr_i`. Enables can be changed in bulk, with write-one-to-set and write-one-to-clear words, or by index, with registers that take an interrupt number. The same two forms exist for clearing status. A global enable and two per-host enables gate the request pins. For each host, a prioritized-index register returns the number of the line that would be serviced.

The block has no nesting, no priority hold and no vectoring. The mapping from channels to hosts is fixed.

Top module: `chan_prio_intc`

## Requirements
- R1: While reset is held, and afterwards with every input at its inactive level, the block is in its reset state. In that state `fiq_o` and `irq_o` are low; the enable, status, global-enable (0x00) and host-enable (0x07) registers read 0; every channel-map word reads 0x0F0F0F0F; and both prioritized-index registers read 0x8000_0000.
- R2: For source i, the polarity bit and the type bit are bit i%32 of word 0x20+i/32 and of word 0x24+i/32. With type 0 (level), status follows the qualified input one cycle later: active high when polarity is 1, active low when polarity is 0. A clear does not remove level status while the input stays active.
- R3: With type 1 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) sets status one cycle after the edge. Status then stays set after the input returns, until it is cleared. Status is read at word 0x18+i/32.
- R4: Writing number i to 0x02 sets only the enable of source i. Writing i to 0x03 clears only that enable. A number of NUM_SRC or more changes nothing. Enables are read at word 0x10+i/32.
- R5: Writing number i to 0x04 clears the pending status of edge source i, which acknowledges it.
- R6: Writing a mask to 0x10+w sets the enables under its 1 bits. Writing a mask to 0x14+w clears them. Writing a mask to 0x1C+w clears the status bits under its 1 bits.
- R7: Source 4n+j takes its channel from byte j of map word 0x40+n, where byte 0 is the least significant byte. Map words can be written and read back.
- R8: An enabled pending source on channel 0 or 1 drives `fiq_o`. One on channels 2 to 31 drives `irq_o`. A channel byte of 32 or more routes the source nowhere.
- R9: For each host, the index register (0x08 for fast, 0x09 for normal) returns the number of the source on the lowest-numbered live channel. If several sources share that channel, the lowest source number wins. Bit 31 of the register is set when no source qualifies.
- R10: Bit 0 of 0x00 (global enable) gates both request pins. Writing host number 0 or 1 to 0x05 enables that host, and writing it to 0x06 disables that host; host 0 is the fast host and host 1 the normal host. Neither enable changes the index registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | System interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A one-hot sweep over all 64 sources shows that each index enable reaches exactly the intended line and that the reported index follows the single active source. A sweep of one source across channel numbers 0 to 33 separates the fast channels, the normal channels and the out-of-range bytes. Overlapping sources on different channels and on the same channel tell the channel ordering apart from the tie-break on source number. Pulses, held levels and polarity flips on a few lines separate latched edge status from level status that follows its input, and show that a clear works only on the former.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam int A_GLB       = 8'h00;
  localparam int A_ENA_ISET  = 8'h02;
  localparam int A_ENA_ICLR  = 8'h03;
  localparam int A_STAT_ICLR = 8'h04;
  localparam int A_HOST_ISET = 8'h05;
  localparam int A_HOST_ICLR = 8'h06;
  localparam int A_HOST      = 8'h07;
  localparam int A_FIQ_IDX   = 8'h08;
  localparam int A_IRQ_IDX   = 8'h09;
  localparam int A_ENA_SET   = 8'h10;
  localparam int A_ENA_CLR   = 8'h14;
  localparam int A_STAT      = 8'h18;
  localparam int A_STAT_CLR  = 8'h1C;
  localparam int A_POL       = 8'h20;
  localparam int A_TYPE      = 8'h24;
  localparam int A_MAP       = 8'h40;

  localparam logic [7:0]  MAP_RST  = 8'h0F;
  localparam logic [31:0] IDX_NONE = 32'h8000_0000;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] typ_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic qual, qual_prev, edge_hit;
    // polarity 1: active high / rising; polarity 0: active low / falling
    assign qual      = pol_i[i] ? src_i[i]  : ~src_i[i];
    assign qual_prev = pol_i[i] ? prev_q[i] : ~prev_q[i];
    assign edge_hit  = qual & ~qual_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= 1'b0;
        stat_o[i] <= 1'b0;
      end else begin
        prev_q[i] <= src_i[i];
        if (typ_i[i]) stat_o[i] <= edge_hit | (stat_o[i] & ~clr_i[i]);
        else          stat_o[i] <= qual;
      end
    end
  end
endmodule

// File: rtl/intc_prio_sel.sv
module intc_prio_sel #(
  parameter int NUM_SRC = 64,
  parameter int CH_LO   = 0,
  parameter int CH_HI   = 1,
  localparam int IW     = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]   act_i,
  input  logic [NUM_SRC*8-1:0] map_i,
  output logic                 any_o,
  output logic [31:0]          idx_o
);
  logic [7:0]    best_ch;
  logic [IW-1:0] best_idx;
  logic          found;

  always_comb begin
    found    = 1'b0;
    best_ch  = 8'hFF;
    best_idx = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      // strict less-than keeps the lowest source number on a tie
      if (act_i[s] && map_i[s*8 +: 8] >= 8'(CH_LO) && map_i[s*8 +: 8] <= 8'(CH_HI)
          && (!found || map_i[s*8 +: 8] < best_ch)) begin
        found    = 1'b1;
        best_ch  = map_i[s*8 +: 8];
        best_idx = IW'(s);
      end
    end
  end

  assign any_o = found;
  assign idx_o = found ? 32'(best_idx) : intc_pkg::IDX_NONE;
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int NW     = NUM_SRC / 32,
  localparam int NMW    = NUM_SRC / 4,
  localparam int IW     = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DW-1:0]        rd_data_o,
  input  logic [NUM_SRC-1:0]   stat_i,
  input  logic [31:0]          fiq_idx_i,
  input  logic [31:0]          irq_idx_i,
  output logic [NUM_SRC-1:0]   ena_o,
  output logic [NUM_SRC-1:0]   pol_o,
  output logic [NUM_SRC-1:0]   typ_o,
  output logic [NUM_SRC*8-1:0] map_o,
  output logic [NUM_SRC-1:0]   stat_clr_o,
  output logic                 glb_o,
  output logic [1:0]           host_o
);
  logic               idx_ok;
  logic [IW-1:0]      idx;
  logic [NUM_SRC-1:0] ena_set, ena_clr;

  assign idx_ok = wr_data_i < NUM_SRC;
  assign idx    = wr_data_i[IW-1:0];

  always_comb begin
    ena_set    = '0;
    ena_clr    = '0;
    stat_clr_o = '0;
    if (wr_en_i) begin
      if (wr_addr_i == AW'(A_ENA_ISET) && idx_ok)  ena_set[idx]    = 1'b1;
      if (wr_addr_i == AW'(A_ENA_ICLR) && idx_ok)  ena_clr[idx]    = 1'b1;
      if (wr_addr_i == AW'(A_STAT_ICLR) && idx_ok) stat_clr_o[idx] = 1'b1;
      for (int w = 0; w < NW; w++) begin
        if (wr_addr_i == AW'(A_ENA_SET + w))  ena_set[w*32 +: 32]    = wr_data_i;
        if (wr_addr_i == AW'(A_ENA_CLR + w))  ena_clr[w*32 +: 32]    = wr_data_i;
        if (wr_addr_i == AW'(A_STAT_CLR + w)) stat_clr_o[w*32 +: 32] = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_o  <= '0;
      pol_o  <= '0;
      typ_o  <= '0;
      map_o  <= {NUM_SRC{MAP_RST}};
      glb_o  <= 1'b0;
      host_o <= 2'b00;
    end else begin
      ena_o <= (ena_o | ena_set) & ~ena_clr;
      if (wr_en_i) begin
        if (wr_addr_i == AW'(A_GLB)) glb_o <= wr_data_i[0];
        if (wr_addr_i == AW'(A_HOST_ISET) && wr_data_i < 2) host_o[wr_data_i[0]] <= 1'b1;
        if (wr_addr_i == AW'(A_HOST_ICLR) && wr_data_i < 2) host_o[wr_data_i[0]] <= 1'b0;
        for (int w = 0; w < NW; w++) begin
          if (wr_addr_i == AW'(A_POL + w))  pol_o[w*32 +: 32] <= wr_data_i;
          if (wr_addr_i == AW'(A_TYPE + w)) typ_o[w*32 +: 32] <= wr_data_i;
        end
        for (int n = 0; n < NMW; n++) begin
          if (wr_addr_i == AW'(A_MAP + n)) map_o[n*32 +: 32] <= wr_data_i;
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(A_GLB))     rd_data_o = 32'(glb_o);
    if (rd_addr_i == AW'(A_HOST))    rd_data_o = 32'(host_o);
    if (rd_addr_i == AW'(A_FIQ_IDX)) rd_data_o = fiq_idx_i;
    if (rd_addr_i == AW'(A_IRQ_IDX)) rd_data_o = irq_idx_i;
    for (int w = 0; w < NW; w++) begin
      if (rd_addr_i == AW'(A_ENA_SET + w)) rd_data_o = ena_o[w*32 +: 32];
      if (rd_addr_i == AW'(A_STAT + w))    rd_data_o = stat_i[w*32 +: 32];
      if (rd_addr_i == AW'(A_POL + w))     rd_data_o = pol_o[w*32 +: 32];
      if (rd_addr_i == AW'(A_TYPE + w))    rd_data_o = typ_o[w*32 +: 32];
    end
    for (int n = 0; n < NMW; n++) begin
      if (rd_addr_i == AW'(A_MAP + n)) rd_data_o = map_o[n*32 +: 32];
    end
  end
endmodule

// File: rtl/chan_prio_intc.sv
module chan_prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CHAN  = 32,
  parameter int FIQ_CHANS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               fiq_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0]   ena_q, pol_q, typ_q, stat_q, stat_clr, act;
  logic [NUM_SRC*8-1:0] map_q;
  logic                 glb_q;
  logic [1:0]           host_q;
  logic [1:0]           host_any;
  logic [31:0]          host_idx [2];
  logic [31:0]          fiq_idx, irq_idx;

  intc_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .stat_i(stat_q), .fiq_idx_i(fiq_idx), .irq_idx_i(irq_idx),
    .ena_o(ena_q), .pol_o(pol_q), .typ_o(typ_q), .map_o(map_q),
    .stat_clr_o(stat_clr), .glb_o(glb_q), .host_o(host_q)
  );

  intc_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk_i, .rst_ni, .src_i, .pol_i(pol_q), .typ_i(typ_q),
    .clr_i(stat_clr), .stat_o(stat_q)
  );

  assign act = stat_q & ena_q;

  for (genvar h = 0; h < 2; h++) begin : g_host
    intc_prio_sel #(
      .NUM_SRC(NUM_SRC),
      .CH_LO  (h == 0 ? 0 : FIQ_CHANS),
      .CH_HI  (h == 0 ? FIQ_CHANS - 1 : NUM_CHAN - 1)
    ) u_sel (
      .act_i(act), .map_i(map_q), .any_o(host_any[h]), .idx_o(host_idx[h])
    );
  end

  assign fiq_idx = host_idx[0];
  assign irq_idx = host_idx[1];
  assign fiq_o   = glb_q & host_q[0] & host_any[0];
  assign irq_o   = glb_q & host_q[1] & host_any[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IW     = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [DW-1:0]      wr_data_i,
  input logic [NUM_SRC-1:0] ena_q,
  input logic               glb_q,
  input logic [31:0]        fiq_idx,
  input logic [31:0]        irq_idx,
  input logic               fiq_o,
  input logic               irq_o
);
  AST_GLB_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_q |-> (!fiq_o && !irq_o)); // R10

  AST_ENA_ISET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(A_ENA_ISET) && wr_data_i < NUM_SRC)
    |=> ena_q[$past(wr_data_i[IW-1:0])]); // R4

  AST_ENA_ICLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(A_ENA_ICLR) && wr_data_i < NUM_SRC)
    |=> !ena_q[$past(wr_data_i[IW-1:0])]); // R4

  AST_FIQ_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_idx[31] |-> !fiq_o); // R9

  AST_IRQ_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_idx[31] |-> !irq_o); // R9
endmodule

bind chan_prio_intc intc_checker #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .ena_q(ena_q), .glb_q(glb_q), .fiq_idx(fiq_idx),
  .irq_idx(irq_idx), .fiq_o(fiq_o), .irq_o(irq_o)
);

// File: tb/chan_prio_intc_tb_top.sv
module chan_prio_intc_tb_top;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          fiq, irq;
  int            n_chk = 0;
  int            n_err = 0;
  int            cyc = 0;

  always #10 clk = ~clk;

  chan_prio_intc #(.NUM_SRC(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .fiq_o(fiq), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rd(string req, int a, logic [31:0] exp);
    rd_addr = 8'(a); #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    tick(3);
    // R1: reset state with inputs inactive (all high, active-low level default)
    chk_rd("R1 fiq idx in reset", 8'h08, 32'h8000_0000);
    rst_n = 1'b1;
    tick(2);
    chk("R1 fiq_o", 32'(fiq), 0);
    chk("R1 irq_o", 32'(irq), 0);
    chk_rd("R1 glb", 8'h00, 0);
    chk_rd("R1 host", 8'h07, 0);
    chk_rd("R1 ena w0", 8'h10, 0);
    chk_rd("R1 stat w0", 8'h18, 0);
    chk_rd("R1 stat w1", 8'h19, 0);
    chk_rd("R1 irq idx", 8'h09, 32'h8000_0000);
    for (int n = 0; n < NS / 4; n++) chk_rd("R1 map", 8'h40 + n, 32'h0F0F0F0F);

    // setup: level, active high, both hosts and global on
    src = '0;
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h21, 32'hFFFF_FFFF);
    wr(8'h05, 0); wr(8'h05, 1); wr(8'h00, 1);
    chk_rd("R10 host read", 8'h07, 3);
    tick(2);

    // R4/R9/R8: one-hot sweep, default channel 15 -> normal host
    for (int i = 0; i < NS; i++) begin
      src = NS'(1) << i;
      wr(8'h02, i);
      tick(1);
      chk("R4 sweep irq_o", 32'(irq), 1);
      chk("R8 sweep fiq_o", 32'(fiq), 0);
      chk_rd("R9 sweep irq idx", 8'h09, i);
      chk_rd("R9 sweep fiq idx", 8'h08, 32'h8000_0000);
      chk_rd("R4 sweep ena", 8'h10 + i / 32, 32'h1 << (i % 32));
      wr(8'h03, i);
      tick(1);
      chk("R4 sweep clr irq_o", 32'(irq), 0);
      chk_rd("R4 sweep ena lo", 8'h10, 0);
      chk_rd("R4 sweep ena hi", 8'h11, 0);
    end

    // R8/R7: channel sweep for source 0
    src = 1; wr(8'h02, 0);
    for (int c = 0; c < 34; c++) begin
      wr(8'h40, {24'h0F0F0F, 8'(c)});
      tick(1);
      chk("R8 chan fiq_o", 32'(fiq), 32'(c < 2));
      chk("R8 chan irq_o", 32'(irq), 32'(c >= 2 && c < 32));
      chk_rd("R8 chan fiq idx", 8'h08, (c < 2) ? 0 : 32'h8000_0000);
      chk_rd("R8 chan irq idx", 8'h09, (c >= 2 && c < 32) ? 0 : 32'h8000_0000);
    end
    wr(8'h40, 32'h0F0F0F0F); wr(8'h03, 0);

    // R9: channel order, then tie on source number
    wr(8'h41, 32'h0F0F030F);   // src5 -> ch3
    wr(8'h4A, 32'h0F0F0F02);   // src40 -> ch2
    src = '0; src[5] = 1; src[40] = 1;
    wr(8'h02, 5); wr(8'h02, 40);
    tick(1);
    chk_rd("R9 lower channel wins", 8'h09, 40);
    wr(8'h40, 32'h020F0F0F);   // src3 -> ch2
    src[3] = 1; wr(8'h02, 3);
    tick(1);
    chk_rd("R9 tie lowest source", 8'h09, 3);
    wr(8'h4B, 32'h0F0F010F);   // src45 -> ch1
    chk_rd("R7 map readback", 8'h4B, 32'h0F0F010F);
    src[45] = 1; wr(8'h02, 45);
    tick(1);
    chk("R8 fiq_o", 32'(fiq), 1);
    chk_rd("R9 fiq idx", 8'h08, 45);

    // R10: host and global gating
    wr(8'h06, 1);
    chk("R10 irq host off", 32'(irq), 0);
    chk("R10 fiq still on", 32'(fiq), 1);
    chk_rd("R10 idx unaffected", 8'h09, 3);
    chk_rd("R10 host read", 8'h07, 1);
    wr(8'h00, 0);
    chk("R10 glb off fiq", 32'(fiq), 0);
    wr(8'h00, 1); wr(8'h05, 1);
    chk("R10 restored irq", 32'(irq), 1);

    // R6: bulk enable clear/set
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h15, 32'hFFFF_FFFF);
    chk_rd("R6 bulk clr w0", 8'h10, 0);
    chk_rd("R6 bulk clr w1", 8'h11, 0);
    chk("R6 bulk clr irq", 32'(irq), 0);
    wr(8'h10, 32'h8);
    chk_rd("R6 bulk set", 8'h10, 32'h8);
    chk_rd("R6 bulk set idx", 8'h09, 3);
    wr(8'h14, 32'h8);
    for (int n = 0; n < NS / 4; n++) wr(8'h40 + n, 32'h0F0F0F0F);

    // R3/R5: edge sources 20 (rising) and 21 (falling)
    src = '0; src[21] = 1;
    wr(8'h24, 32'h0030_0000);
    wr(8'h20, 32'hFFDF_FFFF);
    tick(1);
    wr(8'h1C, 32'hFFFF_FFFF);
    tick(1);
    chk_rd("R3 edge idle", 8'h18, 0);
    wr(8'h02, 20);
    src[20] = 1; tick(1); src[20] = 0; tick(2);
    chk_rd("R3 rising latched", 8'h18, 32'h0010_0000);
    chk("R3 irq from edge", 32'(irq), 1);
    chk_rd("R3 idx", 8'h09, 20);
    wr(8'h04, 20);
    tick(1);
    chk_rd("R5 index clear", 8'h18, 0);
    chk("R5 irq after ack", 32'(irq), 0);
    src[21] = 0; tick(2);
    chk_rd("R3 falling latched", 8'h18, 32'h0020_0000);
    wr(8'h1C, 32'h0020_0000);
    tick(1);
    chk_rd("R6 bulk status clr", 8'h18, 0);

    // R2: level active low (src30) and active high (src31)
    wr(8'h20, ~32'h4020_0000);
    tick(2);
    chk_rd("R2 active low asserted", 8'h18, 32'h4000_0000);
    src[30] = 1; tick(2);
    chk_rd("R2 active low released", 8'h18, 0);
    src[31] = 1; tick(2);
    chk_rd("R2 active high", 8'h18, 32'h8000_0000);
    wr(8'h04, 31); tick(1);
    chk_rd("R2 level survives clear", 8'h18, 32'h8000_0000);
    src[31] = 0; tick(2);
    chk_rd("R2 level follows", 8'h18, 0);

    // R4: out-of-range index ignored
    wr(8'h02, NS);
    wr(8'h03, NS + 20);
    chk_rd("R4 range w0", 8'h10, 32'h0010_0000);
    chk_rd("R4 range w1", 8'h11, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule